// File: doc/BRIEF.md
# Interrupt Entry Sequencer for an 8-bit Accumulator CPU

This block is the interrupt front end of a small 8-bit processor core with a 16-bit address space. It watches two request pins, both active low. One is a maskable request that acts on its level. The other is a non-maskable request that acts on its edge. Whenever the core signals an instruction boundary, the block decides whether an interrupt is due.

When an interrupt is due, the block takes the memory bus for a fixed seven-cycle entry sequence. It stores the return address and a copy of the status byte on the stack page. It then reads the two-byte handler address from the vector that belongs to the winning request.

At the end of the sequence it pulses a load strobe. With that strobe it presents the new program counter, the new stack pointer and the new status byte, with the interrupt-disable bit set. The core copies these three values into its own registers.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, `busy`, `load`, `mem_we` and `mem_re` are all low.
- R2: If `irq_n` is low and status bit 2 (interrupt disable) of `p_in` is clear in a cycle with `boundary` high, the maskable request is taken. The new program counter is read low byte first from 0xFFFE, then high byte from 0xFFFF.
- R3: If status bit 2 of `p_in` is set, a low `irq_n` at a boundary starts no sequence and makes no bus access.
- R4: If `irq_n` is still low when status bit 2 is presented clear again at a later boundary, the request is taken again at that boundary. No new edge is needed.
- R5: A high-to-low change of `nmi_n` is latched until it is serviced. It is taken at a boundary whatever status bit 2 holds. The handler address is read low byte from 0xFFFA, then high byte from 0xFFFB.
- R6: Holding `nmi_n` low does not produce a second non-maskable entry. Only a return high followed by a new fall does.
- R7: When both requests are due at the same boundary, the non-maskable vector is used.
- R8: The entry writes exactly three bytes, in this order: the high byte of the return address, then its low byte, then the status byte. The addresses are 0x0100+sp, 0x0100+sp-1 and 0x0100+sp-2, with the stack pointer wrapping modulo 256. `sp_out` equals sp-3 modulo 256. A cycle never reads and writes at once.
- R9: If `nmi_n` is already low while reset is held, no non-maskable entry follows reset.
- R10: The stacked status byte equals `p_in` with bit 5 set and bit 4 clear. `p_out` equals `p_in` with bit 2 set.
- R11: `busy` is high from the cycle after the deciding boundary. `load` rises exactly seven clock edges after that boundary, for one cycle, with `pc_out` valid.
- R12: The latched non-maskable request is cleared during the first vector read. A fall of `nmi_n` after that point is taken at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_n | input | 1 | Maskable request, level, active low |
| nmi_n | input | 1 | Non-maskable request, edge, active low |
| boundary | input | 1 | Core is at an instruction boundary |
| pc_in | input | 16 | Return address offered by the core |
| sp_in | input | 8 | Current stack pointer |
| p_in | input | 8 | Current status byte (bit 2 = interrupt disable) |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_we | output | 1 | Bus write strobe |
| mem_re | output | 1 | Bus read strobe |
| mem_rdata | input | 8 | Bus read data, valid in the same cycle |
| busy | output | 1 | Entry sequence in progress |
| load | output | 1 | One-cycle strobe: pc_out, sp_out, p_out are valid |
| pc_out | output | 16 | Handler address |
| sp_out | output | 8 | Stack pointer after the three pushes |
| p_out | output | 8 | Status with interrupt disable set |

## Verification
Most faults in the request front end show up at the next boundary the bench offers, as a sequence that should or should not start. A stale or wrongly reset edge register shows up as a spurious non-maskable entry right after reset. A pending latch that clears too early or too late shows up as a lost or repeated entry on the boundary after a handler starts. Faults in the step counter or stack pointer show up within the seven cycles of the sequence. They appear as writes at the wrong address or in the wrong order, a wrong `sp_out`, or a `load` strobe one edge early or late.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    // Entry steps; order is the bus order of the sequence
    typedef enum logic [2:0] {
        ST_WAIT0   = 3'd0,
        ST_WAIT1   = 3'd1,
        ST_PUSH_HI = 3'd2,
        ST_PUSH_LO = 3'd3,
        ST_PUSH_P  = 3'd4,
        ST_VEC_LO  = 3'd5,
        ST_VEC_HI  = 3'd6
    } step_e;

    localparam int I_BIT = 2;   // interrupt-disable
    localparam int B_BIT = 4;   // break marker
    localparam int U_BIT = 5;   // always-one bit in the stacked copy

endpackage

// File: rtl/irq_req_front.sv
module irq_req_front
    import irq_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n,
    input  logic nmi_n,
    input  logic accept,
    input  logic i_flag,
    input  logic clr_nmi,
    output logic take_nmi,
    output logic take_irq
);

    typedef struct packed {
        logic prev;
        logic pend;
    } front_t;

    front_t front_d, front_q;
    logic   nmi_act, irq_act, nmi_edge, nmi_req;

    always_comb begin
        nmi_act  = ~nmi_n;
        irq_act  = ~irq_n;
        nmi_edge = nmi_act & ~front_q.prev;
        nmi_req  = front_q.pend | nmi_edge;
        take_nmi = accept & nmi_req;
        take_irq = accept & ~nmi_req & irq_act & ~i_flag;

        front_d      = front_q;
        front_d.prev = nmi_act;
        // a fresh edge wins over the clear
        front_d.pend = nmi_edge | (front_q.pend & ~clr_nmi);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            front_q.prev <= ~nmi_n;   // track the pin through reset
            front_q.pend <= 1'b0;
        end else begin
            front_q <= front_d;
        end
    end

endmodule

// File: rtl/entry_bus_drive.sv
module entry_bus_drive
    import irq_seq_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
    localparam int               ADDR_W     = 2 * DATA_W
) (
    input  logic              active,
    input  step_e             step,
    input  logic [ADDR_W-1:0] ret_pc,
    input  logic [DATA_W-1:0] sp,
    input  logic [DATA_W-1:0] stat,
    input  logic [ADDR_W-1:0] vec,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              we,
    output logic              re
);

    logic [DATA_W-1:0] stacked;

    always_comb begin
        stacked        = stat;
        stacked[U_BIT] = 1'b1;
        stacked[B_BIT] = 1'b0;

        addr  = '0;
        wdata = '0;
        we    = 1'b0;
        re    = 1'b0;
        if (active) begin
            case (step)
                ST_PUSH_HI: begin
                    addr  = {STACK_PAGE, sp};
                    wdata = ret_pc[ADDR_W-1 -: DATA_W];
                    we    = 1'b1;
                end
                ST_PUSH_LO: begin
                    addr  = {STACK_PAGE, sp};
                    wdata = ret_pc[DATA_W-1:0];
                    we    = 1'b1;
                end
                ST_PUSH_P: begin
                    addr  = {STACK_PAGE, sp};
                    wdata = stacked;
                    we    = 1'b1;
                end
                ST_VEC_LO: begin
                    addr = vec;
                    re   = 1'b1;
                end
                ST_VEC_HI: begin
                    addr = vec + {{(ADDR_W-1){1'b0}}, 1'b1};
                    re   = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int                  DATA_W     = 8,
    parameter logic [DATA_W-1:0]   STACK_PAGE = 8'h01,
    parameter logic [2*DATA_W-1:0] NMI_VEC    = 16'hFFFA,
    parameter logic [2*DATA_W-1:0] IRQ_VEC    = 16'hFFFE,
    localparam int                 ADDR_W     = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_n,
    input  logic              nmi_n,
    input  logic              boundary,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] p_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              load,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0] p_out
);

    localparam logic [DATA_W-1:0] SP_STEP = {{(DATA_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic              busy;
        step_e             step;
        logic              is_nmi;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] sp;
        logic [DATA_W-1:0] p;
        logic [DATA_W-1:0] lo;
        logic              load;
    } seq_t;

    seq_t              seq_d, seq_q;
    logic              accept, take_nmi, take_irq, clr_nmi;
    logic [ADDR_W-1:0] vec;

    assign accept  = boundary & ~seq_q.busy;
    assign clr_nmi = seq_q.busy & seq_q.is_nmi & (seq_q.step == ST_VEC_LO);
    assign vec     = seq_q.is_nmi ? NMI_VEC : IRQ_VEC;

    irq_req_front i_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_n    (irq_n),
        .nmi_n    (nmi_n),
        .accept   (accept),
        .i_flag   (p_in[I_BIT]),
        .clr_nmi  (clr_nmi),
        .take_nmi (take_nmi),
        .take_irq (take_irq)
    );

    entry_bus_drive #(
        .DATA_W     (DATA_W),
        .STACK_PAGE (STACK_PAGE)
    ) i_bus (
        .active (seq_q.busy),
        .step   (seq_q.step),
        .ret_pc (seq_q.pc),
        .sp     (seq_q.sp),
        .stat   (seq_q.p),
        .vec    (vec),
        .addr   (mem_addr),
        .wdata  (mem_wdata),
        .we     (mem_we),
        .re     (mem_re)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.load = 1'b0;
        if (!seq_q.busy) begin
            if (take_nmi || take_irq) begin
                seq_d.busy   = 1'b1;
                seq_d.step   = ST_WAIT0;
                seq_d.is_nmi = take_nmi;
                seq_d.pc     = pc_in;
                seq_d.sp     = sp_in;
                seq_d.p      = p_in;
            end
        end else begin
            case (seq_q.step)
                ST_WAIT0:   seq_d.step = ST_WAIT1;
                ST_WAIT1:   seq_d.step = ST_PUSH_HI;
                ST_PUSH_HI: begin
                    seq_d.sp   = seq_q.sp - SP_STEP;
                    seq_d.step = ST_PUSH_LO;
                end
                ST_PUSH_LO: begin
                    seq_d.sp   = seq_q.sp - SP_STEP;
                    seq_d.step = ST_PUSH_P;
                end
                ST_PUSH_P: begin
                    seq_d.sp   = seq_q.sp - SP_STEP;
                    seq_d.step = ST_VEC_LO;
                end
                ST_VEC_LO: begin
                    seq_d.lo   = mem_rdata;
                    seq_d.step = ST_VEC_HI;
                end
                ST_VEC_HI: begin
                    seq_d.pc       = {mem_rdata, seq_q.lo};
                    seq_d.p[I_BIT] = 1'b1;
                    seq_d.busy     = 1'b0;
                    seq_d.load     = 1'b1;
                    seq_d.step     = ST_WAIT0;
                end
                default: begin
                    seq_d.busy = 1'b0;
                    seq_d.step = ST_WAIT0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy   = seq_q.busy;
    assign load   = seq_q.load;
    assign pc_out = seq_q.pc;
    assign sp_out = seq_q.sp;
    assign p_out  = seq_q.p;

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
    localparam int               ADDR_W     = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boundary,
    input logic              busy,
    input logic              load,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              i_out
);

    assert_no_rd_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_stack_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[ADDR_W-1:DATA_W] == STACK_PAGE));

    // vector reads land only on the two vector pairs (R2, R5)
    assert_vec_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> ((mem_addr | 16'h0005) == 16'hFFFF));

    assert_seven_cycles_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ##7 load);

    assert_start_at_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(boundary));

    assert_i_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> i_out);

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
    .DATA_W     (DATA_W),
    .STACK_PAGE (STACK_PAGE)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .boundary (boundary),
    .busy     (busy),
    .load     (load),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .i_out    (p_out[2])
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_n = 1'b1;
    logic        nmi_n = 1'b0;
    logic        boundary = 1'b0;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  sp_in = 8'hFF;
    logic [7:0]  p_in = 8'h00;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, mem_re;
    logic [7:0]  mem_rdata;
    logic        busy, load;
    logic [15:0] pc_out;
    logic [7:0]  sp_out, p_out;

    int total = 0;
    int bad = 0;
    int wr_n = 0;
    logic [15:0] wr_addr [0:3];
    logic [7:0]  wr_data [0:3];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
        .boundary(boundary), .pc_in(pc_in), .sp_in(sp_in), .p_in(p_in),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy), .load(load),
        .pc_out(pc_out), .sp_out(sp_out), .p_out(p_out)
    );

    // vector contents: non-maskable -> 0x1234, maskable -> 0x5678
    always_comb begin
        case (mem_addr)
            16'hFFFA: mem_rdata = 8'h34;
            16'hFFFB: mem_rdata = 8'h12;
            16'hFFFE: mem_rdata = 8'h78;
            16'hFFFF: mem_rdata = 8'h56;
            default:  mem_rdata = 8'hEA;
        endcase
    end

    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (wr_n < 4) begin
                wr_addr[wr_n] = mem_addr;
                wr_data[wr_n] = mem_wdata;
            end
            wr_n = wr_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one boundary that must start nothing
    task automatic run_none(input logic [7:0] p, input string tag);
        @(negedge clk);
        pc_in = 16'hA000; sp_in = 8'hF0; p_in = p; boundary = 1'b1;
        wr_n = 0;
        @(negedge clk);
        boundary = 1'b0;
        chk(busy == 1'b0, tag, {31'd0, busy}, 32'd0);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && wr_n == 0 && !mem_re, tag, wr_n, 32'd0);
    endtask

    // one boundary that must start a full entry
    task automatic run_take(input logic [15:0] pc, input logic [7:0] sp,
                            input logic [7:0] p, input bit exp_nmi,
                            input bit late_pulse, input string tag);
        logic [15:0] exp_pc;
        logic [7:0]  exp_stat, exp_p;
        exp_pc   = exp_nmi ? 16'h1234 : 16'h5678;
        exp_stat = (p | 8'h20) & 8'hEF;
        exp_p    = p | 8'h04;
        @(negedge clk);
        pc_in = pc; sp_in = sp; p_in = p; boundary = 1'b1;
        wr_n = 0;
        @(negedge clk);
        boundary = 1'b0;
        chk(busy == 1'b1, {tag, " R11 busy after decision"}, {31'd0, busy}, 32'd1);
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (late_pulse && i == 1) nmi_n = 1'b1;
            if (late_pulse && i == 6) nmi_n = 1'b0;
        end
        chk(load == 1'b0, {tag, " R11 load not early"}, {31'd0, load}, 32'd0);
        @(negedge clk);
        chk(load == 1'b1, {tag, " R11 load at seventh edge"}, {31'd0, load}, 32'd1);
        chk(pc_out == exp_pc, {tag, " R2/R5 vector"}, pc_out, exp_pc);
        chk(sp_out == sp - 8'd3, {tag, " R8 sp_out"}, sp_out, sp - 8'd3);
        chk(p_out == exp_p, {tag, " R10 p_out"}, p_out, exp_p);
        chk(wr_n == 3, {tag, " R8 write count"}, wr_n, 32'd3);
        chk(wr_addr[0] == {8'h01, sp} && wr_data[0] == pc[15:8],
            {tag, " R8 push pc high"}, {wr_addr[0], 8'h00, wr_data[0]},
            {8'h01, sp, 8'h00, pc[15:8]});
        chk(wr_addr[1] == {8'h01, sp - 8'd1} && wr_data[1] == pc[7:0],
            {tag, " R8 push pc low"}, {wr_addr[1], 8'h00, wr_data[1]},
            {8'h01, sp - 8'd1, 8'h00, pc[7:0]});
        chk(wr_addr[2] == {8'h01, sp - 8'd2} && wr_data[2] == exp_stat,
            {tag, " R8/R10 push status"}, {wr_addr[2], 8'h00, wr_data[2]},
            {8'h01, sp - 8'd2, 8'h00, exp_stat});
        @(negedge clk);
        chk(load == 1'b0 && busy == 1'b0, {tag, " R11 single load"},
            {30'd0, load, busy}, 32'd0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9: non-maskable line already low during reset
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && load == 1'b0 && !mem_we && !mem_re, "R1 in reset",
            {28'd0, busy, load, mem_we, mem_re}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && load == 1'b0 && !mem_we && !mem_re, "R1 after reset",
            {28'd0, busy, load, mem_we, mem_re}, 32'd0);
        run_none(8'h00, "R9 no spurious entry after reset");

        nmi_n = 1'b1;
        // R2: level request with mask clear
        @(negedge clk); irq_n = 1'b0;
        run_take(16'hC123, 8'hFD, 8'h00, 1'b0, 1'b0, "R2 irq taken");
        // R3: masked
        run_none(8'h04, "R3 irq masked");
        // R4: still low, mask cleared again
        run_take(16'h8001, 8'hFA, 8'hC3, 1'b0, 1'b0, "R4 irq retaken");
        @(negedge clk); irq_n = 1'b1;

        // R5: edge latched, taken later with mask set
        @(negedge clk); nmi_n = 1'b0;
        repeat (3) @(negedge clk);
        run_take(16'h4455, 8'hE0, 8'h04, 1'b1, 1'b0, "R5 nmi with mask set");
        // R6: line held low gives no second entry
        run_none(8'h00, "R6 held nmi no retrigger");

        // R7: both at one boundary
        @(negedge clk); nmi_n = 1'b1;
        @(negedge clk); nmi_n = 1'b0; irq_n = 1'b0;
        run_take(16'h1357, 8'hD0, 8'h00, 1'b1, 1'b0, "R7 nmi wins");
        @(negedge clk); irq_n = 1'b1;

        // R8: stack pointer wrap
        @(negedge clk); nmi_n = 1'b1; irq_n = 1'b0;
        run_take(16'hBEEF, 8'h01, 8'h81, 1'b0, 1'b0, "R8 sp wrap");
        @(negedge clk); irq_n = 1'b1;

        // R12: new edge after the first vector read is kept
        @(negedge clk); nmi_n = 1'b0;
        run_take(16'h2468, 8'hC0, 8'h00, 1'b1, 1'b1, "R12 first nmi");
        run_take(16'h1235, 8'hBD, 8'h04, 1'b1, 1'b0, "R12 late edge serviced");
        run_none(8'h04, "R12 pending consumed");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule